// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one DMA channel that serves a single peripheral endpoint in a single direction. It holds two buffer slots, A and B. Each slot has a start address and a byte count. The channel works on one slot while software refills the other. When the active slot runs out, the channel moves on by itself to the other slot if that slot is armed, and it records which slot is in use in a status bit.

Software reaches the channel through a small register bus. The status register has three views: a read view, a write-one-to-set view and a write-one-to-clear view. One word selects the direction, byte order, burst length, unit width and endpoint. Each request pulse from the peripheral moves one burst of 4 or 8 units through a single-beat memory port. An interrupt is raised on slot completion or on a memory error.

Top module: `pp_dma_chan`

## Requirements
- R1: After reset, every register reads zero, `irq` is low and `mem_valid` is low.
- R2: Register byte offsets are: 0x00 device word, 0x04 status set view, 0x08 status clear view, 0x0C status read view, 0x10/0x14 slot A address/count, 0x18/0x1C slot B address/count. A 1 written at 0x04 sets that status bit and a 1 written at 0x08 clears it. Zero bits have no effect, and writes to 0x0C are ignored.
- R3: Status bits are: 0 run, 1 interrupt enable, 2 error, 3 A done, 4 A armed, 5 B done, 6 B armed, 7 slot in use (0 = A). `irq` is high exactly while bit 1 is set and any of bits 2, 3 or 5 is set.
- R4: Device word bit 3 selects the unit width (1 = 2 bytes, 0 = 1 byte) and bit 2 selects the burst length (1 = 8 units, 0 = 4 units). A request while run is set and the slot in use is armed moves one burst. For each unit the slot address rises by the unit size, the count falls by the unit size, and `per_beat` pulses.
- R5: The count never goes below zero: a unit larger than the remaining count leaves zero. A burst ends early when the count reaches zero.
- R6: When the slot in use reaches zero, its done bit is set and its armed bit is cleared. If the other slot is armed, bit 7 switches to it.
- R7: With run set and neither slot armed, requests move nothing. Arming only the other slot later switches bit 7 to that slot, and work continues there.
- R8: Clearing run stops memory traffic mid-burst. Setting run again finishes the same burst from the current address and count.
- R9: A memory error sets the error bit, clears run and moves no unit.
- R10: Device word bit 0 gives the direction (1 = peripheral to memory, shown on `mem_write`). Bits 7:4 appear on `per_sel`. For 2-byte units with bit 1 (big-endian) set, the two bytes are swapped between the peripheral and memory sides. 1-byte units use the low byte only, with the high byte zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| per_req | input | 1 | Peripheral burst request |
| per_beat | output | 1 | One unit moved this cycle |
| per_burst_end | output | 1 | Last unit of the current burst |
| per_sel | output | 4 | Selected peripheral endpoint |
| per_rdata | input | 16 | Data from the peripheral |
| per_wdata | output | 16 | Data to the peripheral |
| mem_valid | output | 1 | Memory access request |
| mem_write | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 2 bytes |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data |
| mem_ready | input | 1 | Access accepted |
| mem_err | input | 1 | Access failed |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is the hand-over between slots. The bench arms both slots with short counts, so that one request drains A and the next runs on B with no software step between them. It then drains B with A unarmed and issues a request to the idle channel. After that it re-arms only A to force the switch back. A pause is placed inside a burst by clearing run just after the first units go through. The bench then checks that the count and address stay consistent across the gap and that the burst total is still exact after resume.

// File: rtl/pp_dma_chan.sv
module pp_dma_chan #(
  parameter int AW = 32,
  parameter int CW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [4:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          per_req,
  output logic          per_beat,
  output logic          per_burst_end,
  output logic [3:0]    per_sel,
  input  logic [15:0]   per_rdata,
  output logic [15:0]   per_wdata,
  output logic          mem_valid,
  output logic          mem_write,
  output logic          mem_wide,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  input  logic          mem_ready,
  input  logic          mem_err,
  output logic          irq
);
  localparam int BW = 3;

  logic [7:0]    dev, st, st_n;
  logic [AW-1:0] sa0, sa1;
  logic [CW-1:0] cnt0, cnt1, cnt_cur, cnt_nxt, unit;
  logic          busy;
  logic [BW-1:0] beat, blen_m1;
  logic          cur, armed_cur, armed_oth, run;
  logic          beat_ok, err_ev, last, zero_go, fin, go, swap;

  assign cur       = st[7];
  assign run       = st[0];
  assign armed_cur = cur ? st[6] : st[4];
  assign armed_oth = cur ? st[4] : st[6];
  assign cnt_cur   = cur ? cnt1 : cnt0;
  assign unit      = dev[3] ? CW'(2) : CW'(1);
  assign cnt_nxt   = (cnt_cur > unit) ? cnt_cur - unit : '0;
  assign blen_m1   = dev[2] ? BW'(7) : BW'(3);

  assign mem_valid = busy & run;
  assign beat_ok   = mem_valid & mem_ready & ~mem_err;
  assign err_ev    = mem_valid & mem_err;
  assign last      = beat_ok & (cnt_nxt == '0);
  assign zero_go   = ~busy & run & armed_cur & (cnt_cur == '0);
  assign fin       = last | zero_go;
  assign go        = ~busy & run & armed_cur & (cnt_cur != '0) & per_req;

  assign per_beat      = beat_ok;
  assign per_burst_end = beat_ok & (last | (beat == blen_m1));
  assign per_sel       = dev[7:4];
  assign mem_write     = dev[0];
  assign mem_wide      = dev[3];
  assign mem_addr      = cur ? sa1 : sa0;
  assign swap          = dev[1] & dev[3];
  assign mem_wdata     = swap ? {per_rdata[7:0], per_rdata[15:8]} :
                         dev[3] ? per_rdata : {8'h00, per_rdata[7:0]};
  assign per_wdata     = swap ? {mem_rdata[7:0], mem_rdata[15:8]} :
                         dev[3] ? mem_rdata : {8'h00, mem_rdata[7:0]};
  assign irq           = st[1] & (st[2] | st[3] | st[5]);

  always_comb begin
    st_n = st;
    if (~busy & ~armed_cur & armed_oth) st_n[7] = ~cur;
    if (fin) begin
      st_n[cur ? 5 : 3] = 1'b1;
      st_n[cur ? 6 : 4] = 1'b0;
      if (armed_oth) st_n[7] = ~cur;
    end
    if (err_ev) begin
      st_n[2] = 1'b1;
      st_n[0] = 1'b0;
    end
    if (reg_wr && reg_addr == 5'h04) st_n = st_n | reg_wdata[7:0];
    if (reg_wr && reg_addr == 5'h08) st_n = st_n & ~reg_wdata[7:0];
  end

  always_comb begin
    case (reg_addr)
      5'h00:               reg_rdata = {24'h0, dev};
      5'h04, 5'h08, 5'h0C: reg_rdata = {24'h0, st};
      5'h10:               reg_rdata = 32'(sa0);
      5'h14:               reg_rdata = 32'(cnt0);
      5'h18:               reg_rdata = 32'(sa1);
      5'h1C:               reg_rdata = 32'(cnt1);
      default:             reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev  <= '0;
      st   <= '0;
      sa0  <= '0;
      sa1  <= '0;
      cnt0 <= '0;
      cnt1 <= '0;
      busy <= 1'b0;
      beat <= '0;
    end else begin
      st <= st_n;
      if (go) begin
        busy <= 1'b1;
        beat <= '0;
      end else if (err_ev) begin
        busy <= 1'b0;
      end else if (beat_ok) begin
        beat <= beat + BW'(1);
        if (last || beat == blen_m1) busy <= 1'b0;
        if (cur) begin
          sa1  <= sa1 + AW'(unit);
          cnt1 <= cnt_nxt;
        end else begin
          sa0  <= sa0 + AW'(unit);
          cnt0 <= cnt_nxt;
        end
      end
      if (reg_wr) begin
        case (reg_addr)
          5'h00: dev  <= reg_wdata[7:0];
          5'h10: sa0  <= reg_wdata[AW-1:0];
          5'h14: cnt0 <= reg_wdata[CW-1:0];
          5'h18: sa1  <= reg_wdata[AW-1:0];
          5'h1C: cnt1 <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

module pp_dma_chan_chk #(
  parameter int AW = 32,
  parameter int CW = 13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic [7:0]    st,
  input logic [7:0]    dev,
  input logic [AW-1:0] sa0,
  input logic [CW-1:0] cnt0,
  input logic [CW-1:0] cnt1,
  input logic          per_beat,
  input logic          mem_valid,
  input logic          mem_err,
  input logic          irq
);
  // R5
  cnt0_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> cnt0 <= $past(cnt0));
  // R5
  cnt1_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_wr |=> cnt1 <= $past(cnt1));
  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_beat && !st[7] && !reg_wr) |=> sa0 == $past(sa0 + (dev[3] ? AW'(2) : AW'(1))));
  // R9
  err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_err && !reg_wr) |=> (!st[0] && st[2]));
  // R8
  pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !st[0] |-> !mem_valid);
  // R6
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(st[4]) && !$past(reg_wr)) |-> st[3]);
  // R3
  irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> st[1]);
endmodule

bind pp_dma_chan pp_dma_chan_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .st(st), .dev(dev),
  .sa0(sa0), .cnt0(cnt0), .cnt1(cnt1), .per_beat(per_beat),
  .mem_valid(mem_valid), .mem_err(mem_err), .irq(irq)
);

// File: tb/test_pp_dma_chan.sv
module test_pp_dma_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        per_req = 1'b0;
  logic        per_beat, per_burst_end;
  logic [3:0]  per_sel;
  logic [15:0] per_rdata = 16'hC3A7;
  logic [15:0] per_wdata;
  logic        mem_valid, mem_write, mem_wide;
  logic [31:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] mem_rdata = 16'hBEEF;
  logic        err_inj = 1'b0;
  logic        mem_ready, mem_err, irq;

  assign mem_ready = mem_valid & ~err_inj;
  assign mem_err   = mem_valid & err_inj;

  always #2 clk = ~clk;

  pp_dma_chan i_pp_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .per_req(per_req),
    .per_beat(per_beat), .per_burst_end(per_burst_end), .per_sel(per_sel),
    .per_rdata(per_rdata), .per_wdata(per_wdata), .mem_valid(mem_valid),
    .mem_write(mem_write), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
    .mem_err(mem_err), .irq(irq)
  );

  int n_chk = 0, n_bad = 0, nbeat = 0;
  bit finished = 1'b0;
  logic [15:0] last_pw, last_mw;
  logic        last_mwr;

  always @(negedge clk) if (per_beat) begin
    nbeat++;
    last_pw  = per_wdata;
    last_mw  = mem_wdata;
    last_mwr = mem_write;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse();
    @(negedge clk); per_req = 1'b1;
    @(negedge clk); per_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // dev, count, beats, count after, address step, status
  localparam logic [59:0] VEC [0:5] = '{
    {8'h00, 16'd100, 4'd4, 16'd96, 8'd4,  8'h11},
    {8'h04, 16'd100, 4'd8, 16'd92, 8'd8,  8'h11},
    {8'h08, 16'd100, 4'd4, 16'd92, 8'd8,  8'h11},
    {8'h0C, 16'd100, 4'd8, 16'd84, 8'd16, 8'h11},
    {8'h09, 16'd3,   4'd2, 16'd0,  8'd4,  8'h09},
    {8'h01, 16'd2,   4'd2, 16'd0,  8'd2,  8'h09}
  };

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual hang expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int b0;
    idle(3);
    #1 chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_valid", 32'(mem_valid), 0);
    rst_n = 1'b1;
    rd(5'h0C, v); chk("R1 status", v, 0);
    rd(5'h14, v); chk("R1 count A", v, 0);
    rd(5'h10, v); chk("R1 addr A", v, 0);

    // R4 R5 table walk
    for (int i = 0; i < 6; i++) begin
      wr(5'h08, 32'hFF);
      wr(5'h00, 32'(VEC[i][59:52]));
      wr(5'h10, 32'h1000);
      wr(5'h14, 32'(VEC[i][51:36]));
      wr(5'h04, 32'h11);
      nbeat = 0;
      pulse();
      idle(14);
      chk($sformatf("R4 beats vec%0d", i), nbeat, 32'(VEC[i][35:32]));
      rd(5'h14, v); chk($sformatf("R5 count vec%0d", i), v, 32'(VEC[i][31:16]));
      rd(5'h10, v); chk($sformatf("R4 addr vec%0d", i), v, 32'h1000 + 32'(VEC[i][15:8]));
      rd(5'h0C, v); chk($sformatf("R6 status vec%0d", i), v, 32'(VEC[i][7:0]));
    end

    // R2 set/clear views
    wr(5'h08, 32'hFF);
    wr(5'h04, 32'h02); rd(5'h0C, v); chk("R2 set", v, 32'h02);
    wr(5'h04, 32'h00); rd(5'h0C, v); chk("R2 set zero", v, 32'h02);
    wr(5'h0C, 32'hFF); rd(5'h0C, v); chk("R2 read view write", v, 32'h02);
    wr(5'h08, 32'h00); rd(5'h0C, v); chk("R2 clear zero", v, 32'h02);
    rd(5'h04, v); chk("R2 set view reads status", v, 32'h02);

    // R3 interrupt
    #1 chk("R3 ie only", 32'(irq), 0);
    wr(5'h04, 32'h04); #1 chk("R3 error", 32'(irq), 1);
    wr(5'h08, 32'h02); #1 chk("R3 ie off", 32'(irq), 0);
    wr(5'h04, 32'h02); wr(5'h08, 32'h04); #1 chk("R3 cleared", 32'(irq), 0);
    wr(5'h04, 32'h20); #1 chk("R3 B done", 32'(irq), 1);
    wr(5'h04, 32'h08); wr(5'h08, 32'h20); #1 chk("R3 A done", 32'(irq), 1);

    // R6 ping-pong
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'h00);
    wr(5'h10, 32'h2000); wr(5'h14, 32'd4);
    wr(5'h18, 32'h3000); wr(5'h1C, 32'd4);
    wr(5'h04, 32'h51);
    pulse(); idle(10);
    rd(5'h0C, v); chk("R6 A to B", v, 32'hC9);
    pulse(); idle(10);
    rd(5'h0C, v); chk("R6 B done", v, 32'hA9);
    rd(5'h18, v); chk("R6 B addr", v, 32'h3004);

    // R7 idle then re-arm A
    nbeat = 0;
    pulse(); idle(10);
    chk("R7 idle beats", nbeat, 0);
    wr(5'h10, 32'h4000); wr(5'h14, 32'd8);
    wr(5'h04, 32'h10);
    pulse(); idle(10);
    chk("R7 resumed beats", nbeat, 4);
    rd(5'h14, v); chk("R7 count A", v, 4);
    rd(5'h0C, v); chk("R7 status", v, 32'h39);

    // R8 pause and resume
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'h04);
    wr(5'h10, 32'h5000); wr(5'h14, 32'd100);
    wr(5'h04, 32'h11);
    nbeat = 0;
    pulse();
    wr(5'h08, 32'h01);
    idle(2);
    b0 = nbeat;
    idle(10);
    chk("R8 no beats while paused", nbeat, b0);
    #1 chk("R8 mem idle", 32'(mem_valid), 0);
    rd(5'h14, v); chk("R8 count at pause", v, 32'(100 - b0));
    chk("R8 paused mid burst", 32'(b0 > 0 && b0 < 8), 1);
    wr(5'h04, 32'h01);
    idle(12);
    chk("R8 total beats", nbeat, 8);
    rd(5'h14, v); chk("R8 count after", v, 92);
    rd(5'h10, v); chk("R8 addr after", v, 32'h5008);

    // R9 memory error
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'h00);
    wr(5'h10, 32'h6000); wr(5'h14, 32'd100);
    wr(5'h04, 32'h13);
    err_inj = 1'b1;
    nbeat = 0;
    pulse(); idle(6);
    err_inj = 1'b0;
    idle(4);
    chk("R9 beats", nbeat, 0);
    rd(5'h0C, v); chk("R9 status", v, 32'h16);
    #1 chk("R9 irq", 32'(irq), 1);

    // R10 data lanes and endpoint
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'hDA);
    #1 chk("R10 per_sel", 32'(per_sel), 32'hD);
    wr(5'h10, 32'h7000); wr(5'h14, 32'd100);
    wr(5'h04, 32'h11);
    pulse(); idle(10);
    chk("R10 swapped to peripheral", 32'(last_pw), 32'hEFBE);
    chk("R10 read direction", 32'(last_mwr), 0);
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'h19);
    wr(5'h04, 32'h11);
    pulse(); idle(10);
    chk("R10 wide little endian", 32'(last_mw), 32'hC3A7);
    chk("R10 write direction", 32'(last_mwr), 1);
    wr(5'h08, 32'hFF);
    wr(5'h00, 32'h23);
    wr(5'h04, 32'h11);
    pulse(); idle(10);
    chk("R10 byte unit", 32'(last_mw), 32'h00A7);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule